// File: doc/BRIEF.md
# Interrupt Context Flag and Return Stack Controller

This block keeps track of which execution context a small 8-bit processor core is running in, and gives each context its own carry and sign flags. Normal mode has one flag pair, and each interrupt level has one more. When an ALU result is reported, only the pair of the active context changes. Taking an interrupt makes that level's pair the active one. The pair keeps whatever value it held when that level last ran, because nothing clears a pair on a switch.

Return addresses live in a stack held in an external 256-byte register RAM. Each stack level takes two bytes, and the stack grows downward from the top address. A subroutine call and an interrupt entry both push a two-byte frame. For an interrupt, the frame also holds the flags of the context that was interrupted. A return from interrupt reads the frame back, reloads the program counter, writes the saved flags into the context being resumed and makes that context active again. A plain return reloads only the program counter and leaves every flag pair alone.

The core drives one-cycle strobes and the current program counter. The block answers on its RAM port, with a one-cycle return-address load pulse, and with a busy signal that is high while a frame is being moved. If a push would create the 128th level, the push is refused and a sticky overflow flag is set.

Top module: `ctx_stack_ctrl`

## Requirements
- R1: While reset is applied and after it is released, busy, RAM write, RAM read, the address-load pulse, the overflow flag and the active carry and sign read 0. The stack pointer starts at 255 with no levels in use, and normal mode is active.
- R2: When the update strobe is high, the active carry takes the overflow input and the active sign takes the underflow input, and both are visible on the next cycle. When the strobe is low, both flags hold their value whatever the other two inputs do.
- R3: A call or an interrupt entry writes one frame over two cycles. In the cycle after the strobe, the upper byte goes to address SP. In the cycle after that, the lower byte (PC bits 7..0) goes to address SP-1. SP then drops by 2. In the upper byte, bits 4..0 hold PC bits 12..8, bit 5 is 1 for an interrupt frame and 0 for a call frame, bit 7 is carry and bit 6 is sign.
- R4: A call frame writes 0 into bits 7..5 of its upper byte. The return that matches a call reloads the saved PC and leaves the active flags exactly as they were before the return.
- R5: Interrupt entry at level L writes the flags of the interrupted context into the frame. From the cycle after the second write, it makes bank L the active pair, with the value that bank last held.
- R6: A return from interrupt reads SP+1 and then SP+2. Two cycles after the second read, it raises the address-load pulse for exactly one cycle with the saved PC. In that same cycle the active flags are the ones saved in the frame, and the interrupted context is active again.
- R7: Busy is high for exactly the 2 cycles of a push and the 3 cycles of a pop. The RAM port is idle whenever busy is low. Strobes that arrive while busy is high are ignored.
- R8: When 127 levels are in use, a further call or interrupt entry writes nothing, leaves the stack unchanged and sets the overflow flag. The flag stays set until reset.
- R9: A return or a return from interrupt with no levels in use is ignored. A return from interrupt while normal mode is active is also ignored. In both cases there is no RAM access and no busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Subroutine return strobe |
| irq_i | input | 1 | Interrupt entry strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_lvl_i | input | 2 | Level of the interrupt being entered |
| pc_i | input | 13 | Return address to save on a push |
| alu_upd_i | input | 1 | Flag update strobe from the ALU |
| alu_ovf_i | input | 1 | ALU overflow result (new carry) |
| alu_unf_i | input | 1 | ALU underflow result (new sign) |
| ram_we_o | output | 1 | RAM write enable |
| ram_re_o | output | 1 | RAM read enable (data returned one cycle later) |
| ram_addr_o | output | 8 | RAM byte address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data |
| pc_load_o | output | 1 | One-cycle pulse: reload the PC from pc_ret_o |
| pc_ret_o | output | 13 | Restored return address |
| carry_o | output | 1 | Active carry flag |
| sign_o | output | 1 | Active sign flag |
| busy_o | output | 1 | A push or pop is in progress |
| stk_ovf_o | output | 1 | Sticky stack overflow |

## Verification
The bench nests two interrupt levels, places a call inside the inner one and returns in order. A design that restored flags on a plain return, or that wrote the restored flags into the wrong bank, would show the wrong carry or sign in the cycle of the address-load pulse. The bench then re-enters a level and checks that the bank still holds its old value, which catches a design that clears banks on entry. Strobes during busy, pops on an empty stack and a return from interrupt in normal mode would start a stray RAM access if they were not ignored. Filling the stack to 127 levels shows whether a design writes below address 2 or forgets the overflow flag.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_POP_LO,
    ST_POP_HI,
    ST_POP_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_CALL,
    OP_IRQ,
    OP_RET,
    OP_RETI
  } frame_op_e;

endpackage

// File: rtl/ctx_rst_sync.sv
module ctx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_no = sync_q;

endmodule

// File: rtl/ctx_flag_bank.sv
module ctx_flag_bank #(
  parameter int NUM_LVL = 4,
  localparam int CTX_W = $clog2(NUM_LVL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTX_W-1:0] cur_i,
  input  logic             upd_i,
  input  logic             ovf_i,
  input  logic             unf_i,
  input  logic             rest_we_i,
  input  logic [CTX_W-1:0] rest_idx_i,
  input  logic             rest_carry_i,
  input  logic             rest_sign_i,
  output logic             carry_o,
  output logic             sign_o
);

  logic [NUM_LVL:0] carry_vec;
  logic [NUM_LVL:0] sign_vec;

  for (genvar g = 0; g <= NUM_LVL; g++) begin : g_bank
    logic c_q, s_q, c_d, s_d, en;

    always_comb begin
      en  = 1'b0;
      c_d = c_q;
      s_d = s_q;
      if (rest_we_i && (rest_idx_i == CTX_W'(g))) begin
        en  = 1'b1;
        c_d = rest_carry_i;
        s_d = rest_sign_i;
      end else if (upd_i && (cur_i == CTX_W'(g))) begin
        en  = 1'b1;
        c_d = ovf_i;
        s_d = unf_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        c_q <= 1'b0;
        s_q <= 1'b0;
      end else if (en) begin
        c_q <= c_d;
        s_q <= s_d;
      end
    end

    assign carry_vec[g] = c_q;
    assign sign_vec[g]  = s_q;
  end

  assign carry_o = carry_vec[cur_i];
  assign sign_o  = sign_vec[cur_i];

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
  import ctx_stack_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int NUM_LVL = 4,
  parameter int MAX_LVL = 127,
  localparam int LVL_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
  localparam int CTX_W   = $clog2(NUM_LVL + 1),
  localparam int DEP_W   = $clog2(MAX_LVL + 1),
  localparam int PC_HI_W = PC_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              irq_i,
  input  logic              reti_i,
  input  logic [LVL_W-1:0]  irq_lvl_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              carry_i,
  input  logic              sign_i,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [CTX_W-1:0]  cur_o,
  output logic              rest_we_o,
  output logic [CTX_W-1:0]  rest_idx_o,
  output logic              rest_carry_o,
  output logic              rest_sign_o,
  output logic              pc_load_o,
  output logic [PC_W-1:0]   pc_ret_o,
  output logic              busy_o,
  output logic              ovf_o
);

  localparam logic [ADDR_W-1:0] SP_TOP = {ADDR_W{1'b1}};

  seq_state_e        state_q, state_d;
  frame_op_e         op_q, op_d;
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic [DEP_W-1:0]  dep_q, dep_d;
  logic              ovf_q, ovf_d;
  logic [DATA_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic [CTX_W-1:0]  tgt_q, tgt_d, cur_q, cur_d;
  logic [CTX_W-1:0]  ret_ctx_q [NUM_LVL+1];
  logic [CTX_W-1:0]  ret_ctx_d [NUM_LVL+1];
  logic              pc_load_q, pc_load_d;
  logic [PC_W-1:0]   pc_ret_q, pc_ret_d;

  always_comb begin
    state_d      = state_q;
    op_d         = op_q;
    sp_d         = sp_q;
    dep_d        = dep_q;
    ovf_d        = ovf_q;
    hi_d         = hi_q;
    lo_d         = lo_q;
    tgt_d        = tgt_q;
    cur_d        = cur_q;
    ret_ctx_d    = ret_ctx_q;
    pc_ret_d     = pc_ret_q;
    pc_load_d    = 1'b0;
    rest_we_o    = 1'b0;
    rest_idx_o   = ret_ctx_q[cur_q];
    rest_carry_o = ram_rdata_i[DATA_W-1];
    rest_sign_o  = ram_rdata_i[DATA_W-2];
    ram_we_o     = 1'b0;
    ram_re_o     = 1'b0;
    ram_addr_o   = sp_q;
    ram_wdata_o  = hi_q;
    unique case (state_q)
      ST_IDLE: begin
        if (irq_i || call_i) begin
          if (dep_q == DEP_W'(MAX_LVL)) begin
            ovf_d = 1'b1;
          end else begin
            state_d = ST_PUSH_HI;
            op_d    = irq_i ? OP_IRQ : OP_CALL;
            hi_d    = '0;
            hi_d[PC_HI_W-1:0] = pc_i[PC_W-1:DATA_W];
            if (irq_i) begin
              hi_d[DATA_W-1] = carry_i;
              hi_d[DATA_W-2] = sign_i;
              hi_d[DATA_W-3] = 1'b1;
            end
            lo_d  = pc_i[DATA_W-1:0];
            tgt_d = CTX_W'(irq_lvl_i) + CTX_W'(1);
          end
        end else if (reti_i && (cur_q != '0) && (dep_q != '0)) begin
          state_d = ST_POP_LO;
          op_d    = OP_RETI;
        end else if (ret_i && (dep_q != '0)) begin
          state_d = ST_POP_LO;
          op_d    = OP_RET;
        end
      end
      ST_PUSH_HI: begin
        ram_we_o = 1'b1;
        state_d  = ST_PUSH_LO;
      end
      ST_PUSH_LO: begin
        ram_we_o    = 1'b1;
        ram_addr_o  = sp_q - ADDR_W'(1);
        ram_wdata_o = lo_q;
        sp_d        = sp_q - ADDR_W'(2);
        dep_d       = dep_q + DEP_W'(1);
        state_d     = ST_IDLE;
        if (op_q == OP_IRQ) begin
          ret_ctx_d[tgt_q] = cur_q;
          cur_d            = tgt_q;
        end
      end
      ST_POP_LO: begin
        ram_re_o   = 1'b1;
        ram_addr_o = sp_q + ADDR_W'(1);
        state_d    = ST_POP_HI;
      end
      ST_POP_HI: begin
        ram_re_o   = 1'b1;
        ram_addr_o = sp_q + ADDR_W'(2);
        lo_d       = ram_rdata_i;
        state_d    = ST_POP_FIN;
      end
      ST_POP_FIN: begin
        pc_ret_d  = {ram_rdata_i[PC_HI_W-1:0], lo_q};
        pc_load_d = 1'b1;
        sp_d      = sp_q + ADDR_W'(2);
        dep_d     = dep_q - DEP_W'(1);
        state_d   = ST_IDLE;
        if (op_q == OP_RETI) begin
          cur_d     = ret_ctx_q[cur_q];
          rest_we_o = ram_rdata_i[DATA_W-3];
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_CALL;
      sp_q      <= SP_TOP;
      dep_q     <= '0;
      ovf_q     <= 1'b0;
      hi_q      <= '0;
      lo_q      <= '0;
      tgt_q     <= '0;
      cur_q     <= '0;
      ret_ctx_q <= '{default: '0};
      pc_load_q <= 1'b0;
      pc_ret_q  <= '0;
    end else begin
      state_q   <= state_d;
      op_q      <= op_d;
      sp_q      <= sp_d;
      dep_q     <= dep_d;
      ovf_q     <= ovf_d;
      hi_q      <= hi_d;
      lo_q      <= lo_d;
      tgt_q     <= tgt_d;
      cur_q     <= cur_d;
      ret_ctx_q <= ret_ctx_d;
      pc_load_q <= pc_load_d;
      pc_ret_q  <= pc_ret_d;
    end
  end

  assign cur_o     = cur_q;
  assign pc_load_o = pc_load_q;
  assign pc_ret_o  = pc_ret_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign ovf_o     = ovf_q;

endmodule

// File: rtl/ctx_stack_ctrl.sv
module ctx_stack_ctrl #(
  parameter int PC_W    = 13,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int NUM_LVL = 4,
  parameter int MAX_LVL = 127,
  localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
  localparam int CTX_W  = $clog2(NUM_LVL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              irq_i,
  input  logic              reti_i,
  input  logic [LVL_W-1:0]  irq_lvl_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              alu_upd_i,
  input  logic              alu_ovf_i,
  input  logic              alu_unf_i,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              pc_load_o,
  output logic [PC_W-1:0]   pc_ret_o,
  output logic              carry_o,
  output logic              sign_o,
  output logic              busy_o,
  output logic              stk_ovf_o
);

  logic             rst_sync_n;
  logic [CTX_W-1:0] cur;
  logic             rest_we;
  logic [CTX_W-1:0] rest_idx;
  logic             rest_carry;
  logic             rest_sign;

  ctx_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  ctx_stack_seq #(
    .PC_W    (PC_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NUM_LVL (NUM_LVL),
    .MAX_LVL (MAX_LVL)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .irq_i        (irq_i),
    .reti_i       (reti_i),
    .irq_lvl_i    (irq_lvl_i),
    .pc_i         (pc_i),
    .carry_i      (carry_o),
    .sign_i       (sign_o),
    .ram_we_o     (ram_we_o),
    .ram_re_o     (ram_re_o),
    .ram_addr_o   (ram_addr_o),
    .ram_wdata_o  (ram_wdata_o),
    .ram_rdata_i  (ram_rdata_i),
    .cur_o        (cur),
    .rest_we_o    (rest_we),
    .rest_idx_o   (rest_idx),
    .rest_carry_o (rest_carry),
    .rest_sign_o  (rest_sign),
    .pc_load_o    (pc_load_o),
    .pc_ret_o     (pc_ret_o),
    .busy_o       (busy_o),
    .ovf_o        (stk_ovf_o)
  );

  ctx_flag_bank #(
    .NUM_LVL (NUM_LVL)
  ) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .cur_i        (cur),
    .upd_i        (alu_upd_i),
    .ovf_i        (alu_ovf_i),
    .unf_i        (alu_unf_i),
    .rest_we_i    (rest_we),
    .rest_idx_i   (rest_idx),
    .rest_carry_i (rest_carry),
    .rest_sign_i  (rest_sign),
    .carry_o      (carry_o),
    .sign_o       (sign_o)
  );

endmodule

// File: rtl/ctx_stack_ctrl_chk.sv
module ctx_stack_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ram_we_o,
  input logic              ram_re_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              pc_load_o,
  input logic              busy_o,
  input logic              stk_ovf_o
);

  assert_ram_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && ram_re_o));

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ram_we_o && !ram_re_o));

  assert_busy_starts_access_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (ram_we_o || ram_re_o));

  assert_push_descends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_o) |=> (ram_we_o && (ram_addr_o == ADDR_W'($past(ram_addr_o) - ADDR_W'(1)))));

  assert_pop_ascends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_re_o) |=> (ram_re_o && (ram_addr_o == ADDR_W'($past(ram_addr_o) + ADDR_W'(1)))));

  assert_load_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !pc_load_o);

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_ovf_o |=> stk_ovf_o);

endmodule

bind ctx_stack_ctrl ctx_stack_ctrl_chk #(
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ram_we_o   (ram_we_o),
  .ram_re_o   (ram_re_o),
  .ram_addr_o (ram_addr_o),
  .pc_load_o  (pc_load_o),
  .busy_o     (busy_o),
  .stk_ovf_o  (stk_ovf_o)
);

// File: tb/ctx_stack_ctrl_tb_top.sv
`timescale 1ns/1ps
module ctx_stack_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_s, ret_s, irq_s, reti_s;
  logic [1:0]  lvl_s;
  logic [12:0] pc_s;
  logic        upd_s, ovf_s, unf_s;
  logic        we, re, pc_load, carry, sign, busy, stk_ovf;
  logic [7:0]  addr, wdata;
  logic [7:0]  rdata = 8'h00;
  logic [12:0] pc_ret;
  logic [7:0]  mem [256];

  int   n_chk = 0;
  int   n_bad = 0;
  logic [7:0] exp_sp;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  ctx_stack_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .call_i(call_s), .ret_i(ret_s), .irq_i(irq_s), .reti_i(reti_s),
    .irq_lvl_i(lvl_s), .pc_i(pc_s),
    .alu_upd_i(upd_s), .alu_ovf_i(ovf_s), .alu_unf_i(unf_s),
    .ram_we_o(we), .ram_re_o(re), .ram_addr_o(addr), .ram_wdata_o(wdata),
    .ram_rdata_i(rdata),
    .pc_load_o(pc_load), .pc_ret_o(pc_ret),
    .carry_o(carry), .sign_o(sign), .busy_o(busy), .stk_ovf_o(stk_ovf)
  );

  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic clear_in();
    call_s = 0; ret_s = 0; irq_s = 0; reti_s = 0;
    lvl_s = '0; pc_s = '0; upd_s = 0; ovf_s = 0; unf_s = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clear_in();
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
    exp_sp = 8'hFF;
  endtask

  task automatic alu(input bit c, input bit s, input string req);
    upd_s = 1; ovf_s = c; unf_s = s;
    step();
    upd_s = 0;
    chk(req, "alu carry", carry, c);
    chk(req, "alu sign", sign, s);
  endtask

  task automatic push(input bit is_irq, input logic [1:0] lvl, input logic [12:0] pc,
                      input bit fc, input bit fs, input string req);
    logic [7:0] hi;
    hi = is_irq ? {fc, fs, 1'b1, pc[12:8]} : {3'b000, pc[12:8]};
    if (is_irq) irq_s = 1; else call_s = 1;
    lvl_s = lvl; pc_s = pc;
    step();
    irq_s = 0; call_s = 0;
    chk(req, "push hi we", we, 1);
    chk(req, "push hi addr", addr, exp_sp);
    chk(req, "push hi data", wdata, hi);
    chk(req, "push busy", busy, 1);
    step();
    chk(req, "push lo we", we, 1);
    chk(req, "push lo addr", addr, exp_sp - 8'd1);
    chk(req, "push lo data", wdata, pc[7:0]);
    step();
    chk(req, "push done busy", busy, 0);
    exp_sp = exp_sp - 8'd2;
  endtask

  task automatic pop(input bit is_reti, input logic [12:0] pc, input bit fc, input bit fs,
                     input string req);
    if (is_reti) reti_s = 1; else ret_s = 1;
    step();
    reti_s = 0; ret_s = 0;
    chk(req, "pop rd1", re, 1);
    chk(req, "pop addr1", addr, exp_sp + 8'd1);
    step();
    chk(req, "pop rd2", re, 1);
    chk(req, "pop addr2", addr, exp_sp + 8'd2);
    step();
    chk(req, "pop fin busy", busy, 1);
    chk(req, "pop fin no rd", re, 0);
    step();
    chk(req, "pop load", pc_load, 1);
    chk(req, "pop pc", pc_ret, pc);
    chk(req, "pop carry", carry, fc);
    chk(req, "pop sign", sign, fs);
    chk(req, "pop busy", busy, 0);
    step();
    chk(req, "pop load pulse", pc_load, 0);
    exp_sp = exp_sp + 8'd2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    clear_in();
    step();
    chk("R1", "in-reset busy", busy, 0);
    chk("R1", "in-reset we", we, 0);
    step();
    rst_n = 1'b1;
    step(); step(); step();
    exp_sp = 8'hFF;
    chk("R1", "busy", busy, 0);
    chk("R1", "we", we, 0);
    chk("R1", "re", re, 0);
    chk("R1", "load", pc_load, 0);
    chk("R1", "ovf", stk_ovf, 0);
    chk("R1", "carry", carry, 0);
    chk("R1", "sign", sign, 0);
  endtask

  task automatic t_alu();
    do_reset();
    alu(1, 0, "R2");
    ovf_s = 0; unf_s = 1;
    step(); step();
    chk("R2", "hold carry", carry, 1);
    chk("R2", "hold sign", sign, 0);
    alu(0, 1, "R2");
    alu(0, 0, "R2");
  endtask

  task automatic t_call_ret();
    do_reset();
    alu(1, 1, "R2");
    push(0, 2'd0, 13'h1ABC, 0, 0, "R3");
    alu(0, 1, "R4");
    push(0, 2'd0, 13'h0042, 0, 0, "R4");
    chk("R3", "call frame hi", mem[8'hFF], 8'h1A);
    chk("R3", "call frame lo", mem[8'hFE], 8'hBC);
    pop(0, 13'h0042, 0, 1, "R4");
    alu(1, 0, "R4");
    pop(0, 13'h1ABC, 1, 0, "R4");
  endtask

  task automatic t_irq_nest();
    do_reset();
    alu(1, 0, "R2");
    push(1, 2'd0, 13'h0123, 1, 0, "R5");
    chk("R5", "lvl0 bank carry", carry, 0);
    chk("R5", "lvl0 bank sign", sign, 0);
    alu(1, 1, "R5");
    push(1, 2'd2, 13'h1F00, 1, 1, "R5");
    chk("R5", "lvl2 bank carry", carry, 0);
    chk("R5", "lvl2 bank sign", sign, 0);
    alu(0, 1, "R5");
    push(0, 2'd0, 13'h0777, 0, 0, "R4");
    pop(0, 13'h0777, 0, 1, "R4");
    pop(1, 13'h1F00, 1, 1, "R6");
    alu(0, 0, "R6");
    pop(1, 13'h0123, 1, 0, "R6");
    push(1, 2'd2, 13'h0200, 1, 0, "R5");
    chk("R5", "retained carry", carry, 0);
    chk("R5", "retained sign", sign, 1);
    pop(1, 13'h0200, 1, 0, "R6");
  endtask

  task automatic t_busy_ignore();
    do_reset();
    call_s = 1; pc_s = 13'h0100;
    step();
    call_s = 0;
    chk("R7", "busy in push", busy, 1);
    ret_s = 1; irq_s = 1; reti_s = 1;
    step();
    chk("R7", "still pushing", we, 1);
    step();
    clear_in();
    chk("R7", "busy after push", busy, 0);
    chk("R7", "no write idle", we, 0);
    chk("R7", "no read idle", re, 0);
    step();
    chk("R7", "strobes ignored busy", busy, 0);
    chk("R7", "strobes ignored re", re, 0);
    exp_sp = exp_sp - 8'd2;
    pop(0, 13'h0100, 0, 0, "R7");
  endtask

  task automatic t_empty();
    do_reset();
    ret_s = 1;
    step();
    ret_s = 0;
    chk("R9", "empty ret busy", busy, 0);
    chk("R9", "empty ret re", re, 0);
    reti_s = 1;
    step();
    reti_s = 0;
    chk("R9", "empty reti busy", busy, 0);
    push(0, 2'd0, 13'h0055, 0, 0, "R3");
    reti_s = 1;
    step();
    reti_s = 0;
    chk("R9", "normal reti busy", busy, 0);
    chk("R9", "normal reti re", re, 0);
    pop(0, 13'h0055, 0, 0, "R9");
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 127; i++) begin
      push(0, 2'd0, 13'(i + 16), 0, 0, "R8");
    end
    chk("R8", "sp at limit", exp_sp, 8'h01);
    call_s = 1; pc_s = 13'h1234;
    step();
    call_s = 0;
    chk("R8", "blocked we", we, 0);
    chk("R8", "blocked busy", busy, 0);
    chk("R8", "ovf set", stk_ovf, 1);
    irq_s = 1;
    step();
    irq_s = 0;
    chk("R8", "irq blocked we", we, 0);
    step(); step();
    chk("R8", "ovf sticky", stk_ovf, 1);
    pop(0, 13'd142, 0, 0, "R8");
    chk("R8", "ovf after pop", stk_ovf, 1);
  endtask

  initial begin
    #500us;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    t_reset();
    t_alu();
    t_call_ret();
    t_irq_nest();
    t_busy_ignore();
    t_empty();
    t_overflow();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule